// File: doc/BRIEF.md
# CAN Message Buffer Validity and Identifier Format Control

This block keeps two per-buffer control vectors for a CAN controller with a parameterized number of message buffers (sixteen by default). One vector says which buffers are enabled. The other says whether each buffer uses an 11-bit or a 29-bit identifier. The CPU reaches both vectors over a simple byte-wide bus. The message engine reads both vectors as masks: a buffer whose bit in `valid_mask` is 0 is neither offered for transmission nor allowed to receive.

Software can disable a buffer while the engine is working on it. In that case the block does not drop the valid bit at once. The engine reports, per buffer, whether a transmission is in progress, whether it finished or failed, and whether a received frame is being stored. If the disabled buffer is transmitting or storing a frame, the clear waits until that work is over. If the buffer is only listening for frames, the clear takes effect on the next edge.

Identifier-format bits should be changed only while their buffer is disabled. A write to a format bit of an enabled buffer still takes effect, but it also sets a sticky per-buffer warning flag.

Top module: `can_mbv_ctrl`

## Requirements
- R1: After a synchronous reset, `valid_mask`, `fmt_warn` and `bus_rdata` are all 0. The format bits have no defined reset value.
- R2: The byte addresses are fixed. Address 0 holds enable bits 7:0 and address 1 holds enable bits 15:8. Address 2 holds format bits 7:0 and address 3 holds format bits 15:8. `bus_rdata` shows the addressed byte on the cycle after `bus_rd`, and shows 0 after any cycle without `bus_rd`. Reads of any other address return 0, and writes to any other address change nothing.
- R3: Writing 1 to an enable bit sets the matching `valid_mask` bit on the next edge, whatever the buffer's status inputs are.
- R4: Writing 0 to an enable bit clears it on the next edge when that buffer's `tx_busy` and `rx_store` are both low.
- R5: Writing 0 to a set enable bit while its `tx_busy` is high leaves the bit at 1. The bit clears on the edge of the first later cycle in which `tx_done` or `tx_err` is high, or in which `tx_busy` and `rx_store` are both low.
- R6: Writing 0 to a set enable bit while its `rx_store` is high leaves the bit at 1 until the store ends. The bit clears on the edge of the first later cycle in which `rx_store` and `tx_busy` are both low, or in which `tx_done` or `tx_err` is high.
- R7: Writing 1 to an enable bit whose clear is still waiting cancels that clear, so the bit stays 1 after the activity ends.
- R8: A read of an enable byte returns the bits as they appear on `valid_mask` at that time. A bit whose clear is still waiting reads as 1.
- R9: A format bit written as 0 selects the 11-bit standard identifier and a format bit written as 1 selects the 29-bit extended identifier. The value appears on `ext_id_mask` on the next edge.
- R10: A format byte write to a buffer whose enable bit is 1 still updates its format bit, and it also sets that buffer's `fmt_warn` bit. `fmt_warn` bits stay set until reset. A format write to a disabled buffer sets no warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_busy | input | 16 | Per-buffer transmission in progress |
| tx_done | input | 16 | Per-buffer transmission completed, one-cycle pulse |
| tx_err | input | 16 | Per-buffer transmission ended by error, one-cycle pulse |
| rx_store | input | 16 | Per-buffer received frame being written |
| valid_mask | output | 16 | Effective enable bit of each buffer |
| ext_id_mask | output | 16 | Identifier format per buffer, 1 = 29-bit |
| fmt_warn | output | 16 | Sticky flag: format written while buffer enabled |

## Verification
The assertions expect the engine to pulse `tx_done` or `tx_err` for a buffer only while that buffer's `tx_busy` is high. They also expect the bus to present at most one byte access per cycle. The random stimulus respects both rules: it builds the done and error vectors by masking random words with `tx_busy`, and it draws one address per cycle. Addresses past the four mapped bytes are included in the draw on purpose, so that ignored accesses are exercised. Directed sequences cover clears that must wait for a transmission or for a frame store, a clear cancelled by a later write of 1, a readback while a clear is waiting, and format writes to enabled buffers.

// File: rtl/can_mbv_pkg.sv
package can_mbv_pkg;
  localparam int BYTE_W = 8;

  // byte address of lane k inside a region that starts at base
  function automatic int lane_addr(input int base, input int k);
    return base + k;
  endfunction
endpackage

// File: rtl/can_mbv_bus_dec.sv
module can_mbv_bus_dec
  import can_mbv_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ADDR_W  = 4,
  parameter int V_BASE  = 0,
  parameter int F_BASE  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NUM_BUF-1:0] valid_we,
  output logic [NUM_BUF-1:0] fmt_we,
  output logic [NUM_BUF-1:0] wbit
);
  localparam int LANES = NUM_BUF / BYTE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic hit_v, hit_f;
    assign hit_v = wr && (addr == ADDR_W'(lane_addr(V_BASE, k)));
    assign hit_f = wr && (addr == ADDR_W'(lane_addr(F_BASE, k)));
    assign valid_we[k*BYTE_W +: BYTE_W] = {BYTE_W{hit_v}};
    assign fmt_we[k*BYTE_W +: BYTE_W]   = {BYTE_W{hit_f}};
    assign wbit[k*BYTE_W +: BYTE_W]     = wdata;
  end
endmodule

// File: rtl/can_mbv_valid_cell.sv
module can_mbv_valid_cell (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic wd,
  input  logic tx_busy,
  input  logic tx_done,
  input  logic tx_err,
  input  logic rx_store,
  output logic valid_q
);
  logic pend_q;
  logic active, finish;

  assign active = tx_busy || rx_store;
  assign finish = tx_done || tx_err || !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (we) begin
      if (wd) begin
        valid_q <= 1'b1;
        pend_q  <= 1'b0;
      end else if (valid_q && active) begin
        pend_q  <= 1'b1;
      end else begin
        valid_q <= 1'b0;
        pend_q  <= 1'b0;
      end
    end else if (pend_q && finish) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end
  end

  p_set_next_r3: assert property (@(posedge clk) disable iff (rst)
    (we && wd) |=> valid_q);
  p_clear_now_r4: assert property (@(posedge clk) disable iff (rst)
    (we && !wd && !tx_busy && !rx_store) |=> !valid_q);
  p_hold_tx_r5: assert property (@(posedge clk) disable iff (rst)
    (we && !wd && valid_q && tx_busy) |=> valid_q);
  p_tx_end_r5: assert property (@(posedge clk) disable iff (rst)
    (!we && pend_q && (tx_done || tx_err)) |=> !valid_q);
  p_hold_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (we && !wd && valid_q && rx_store) |=> valid_q);
  p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
    (pend_q && we && wd) |=> (valid_q && !pend_q));
endmodule

// File: rtl/can_mbv_fmt_bank.sv
module can_mbv_fmt_bank #(
  parameter int NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] we,
  input  logic [NUM_BUF-1:0] wd,
  input  logic [NUM_BUF-1:0] valid_now,
  output logic [NUM_BUF-1:0] fmt_q,
  output logic [NUM_BUF-1:0] warn_q
);
  // format bits carry no reset, as in a plain register file
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BUF; i++)
      if (we[i]) fmt_q[i] <= wd[i];
  end

  always_ff @(posedge clk) begin
    if (rst) warn_q <= '0;
    else     warn_q <= warn_q | (we & valid_now);
  end

  p_fmt_write_r9: assert property (@(posedge clk) disable iff (rst)
    (|we) |=> ((fmt_q & $past(we)) == ($past(wd) & $past(we))));
  p_warn_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((warn_q & $past(warn_q)) == $past(warn_q)));
  p_warn_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((warn_q & ~$past(warn_q) & ~($past(we) & $past(valid_now))) == '0));
endmodule

// File: rtl/can_mbv_rd_mux.sv
module can_mbv_rd_mux
  import can_mbv_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ADDR_W  = 4,
  parameter int V_BASE  = 0,
  parameter int F_BASE  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic [NUM_BUF-1:0] valid_v,
  input  logic [NUM_BUF-1:0] fmt_v,
  output logic [BYTE_W-1:0]  rdata
);
  localparam int LANES = NUM_BUF / BYTE_W;

  logic [BYTE_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int k = 0; k < LANES; k++) begin
      if (addr == ADDR_W'(lane_addr(V_BASE, k))) sel = valid_v[k*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(lane_addr(F_BASE, k))) sel = fmt_v[k*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
    else         rdata <= '0;
  end

  p_idle_read_r2: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/can_mbv_ctrl.sv
module can_mbv_ctrl
  import can_mbv_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_BUF-1:0] tx_busy,
  input  logic [NUM_BUF-1:0] tx_done,
  input  logic [NUM_BUF-1:0] tx_err,
  input  logic [NUM_BUF-1:0] rx_store,
  output logic [NUM_BUF-1:0] valid_mask,
  output logic [NUM_BUF-1:0] ext_id_mask,
  output logic [NUM_BUF-1:0] fmt_warn
);
  localparam int LANES  = NUM_BUF / BYTE_W;
  localparam int V_BASE = 0;
  localparam int F_BASE = LANES;

  logic [NUM_BUF-1:0] valid_we, fmt_we, wbit;

  can_mbv_bus_dec #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .V_BASE(V_BASE), .F_BASE(F_BASE)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .valid_we(valid_we), .fmt_we(fmt_we), .wbit(wbit)
  );

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    can_mbv_valid_cell u_cell (
      .clk(clk), .rst(rst), .we(valid_we[i]), .wd(wbit[i]),
      .tx_busy(tx_busy[i]), .tx_done(tx_done[i]), .tx_err(tx_err[i]),
      .rx_store(rx_store[i]), .valid_q(valid_mask[i])
    );
  end

  can_mbv_fmt_bank #(.NUM_BUF(NUM_BUF)) u_fmt (
    .clk(clk), .rst(rst), .we(fmt_we), .wd(wbit), .valid_now(valid_mask),
    .fmt_q(ext_id_mask), .warn_q(fmt_warn)
  );

  can_mbv_rd_mux #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .V_BASE(V_BASE), .F_BASE(F_BASE)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd),
    .valid_v(valid_mask), .fmt_v(ext_id_mask), .rdata(bus_rdata)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (valid_mask == '0 && fmt_warn == '0 && bus_rdata == '0));
  p_offmap_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr >= ADDR_W'(2*LANES) && !(|tx_done) && !(|tx_err)
     && ((tx_busy | rx_store) == '1)) |=> $stable(ext_id_mask));
endmodule

// File: tb/can_mbv_ctrl_test.sv
module can_mbv_ctrl_test;
  localparam int N  = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [N-1:0] tx_busy = '0, tx_done = '0, tx_err = '0, rx_store = '0;
  logic [N-1:0] valid_mask, ext_id_mask, fmt_warn;

  always #5 clk = ~clk;

  can_mbv_ctrl #(.NUM_BUF(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_busy(tx_busy), .tx_done(tx_done),
    .tx_err(tx_err), .rx_store(rx_store), .valid_mask(valid_mask),
    .ext_id_mask(ext_id_mask), .fmt_warn(fmt_warn)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  bit fmt_known = 0;
  logic [N-1:0] m_v = '0, m_p = '0, m_f = '0, m_w = '0;
  logic [7:0] m_rd = '0;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [AW-1:0] a);
    case (a)
      4'd0: return m_v[7:0];
      4'd1: return m_v[15:8];
      4'd2: return m_f[7:0];
      4'd3: return m_f[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // compare outputs against the model, then drive one cycle of stimulus
  task automatic cyc(input logic [AW-1:0] a, input logic w, input logic r, input logic [7:0] d,
                     input logic [N-1:0] busy, input logic [N-1:0] done,
                     input logic [N-1:0] err, input logic [N-1:0] store);
    logic [N-1:0] nv, np, nf, nw;
    @(negedge clk);
    check("R3-R7 valid_mask", valid_mask, m_v);
    if (fmt_known) check("R9 ext_id_mask", ext_id_mask, m_f);
    check("R10 fmt_warn", fmt_warn, m_w);
    check("R2 bus_rdata", {8'h00, bus_rdata}, {8'h00, m_rd});
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    tx_busy = busy; tx_done = done; tx_err = err; rx_store = store;
    m_rd = r ? model_read(a) : 8'h00;
    nv = m_v; np = m_p; nf = m_f; nw = m_w;
    for (int i = 0; i < N; i++) begin
      bit wv, wf, bi;
      wv = w && (a == AW'(i / 8));
      wf = w && (a == AW'(2 + i / 8));
      bi = d[i % 8];
      if (wv) begin
        if (bi) begin nv[i] = 1; np[i] = 0; end
        else if (m_v[i] && (busy[i] || store[i])) np[i] = 1;
        else begin nv[i] = 0; np[i] = 0; end
      end else if (m_p[i] && (done[i] || err[i] || !(busy[i] || store[i]))) begin
        nv[i] = 0; np[i] = 0;
      end
      if (wf) begin
        nf[i] = bi;
        if (m_v[i]) nw[i] = 1;
      end
    end
    m_v = nv; m_p = np; m_f = nf; m_w = nw;
  endtask

  task automatic idle();
    cyc('0, 0, 0, 8'h00, '0, '0, '0, '0);
  endtask

  initial begin
    #(20000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check("R1 valid_mask", valid_mask, '0);
    check("R1 fmt_warn", fmt_warn, '0);
    check("R1 bus_rdata", {8'h00, bus_rdata}, '0);

    // R9 format writes while all buffers are invalid
    cyc(4'd2, 1, 0, 8'hA5, '0, '0, '0, '0);
    cyc(4'd3, 1, 0, 8'h3C, '0, '0, '0, '0);
    fmt_known = 1;
    idle();
    check("R9 ext_id direct", ext_id_mask, 16'h3CA5);
    check("R10 no warn when invalid", fmt_warn, '0);

    // R3 set while busy; R4/R5/R6 clear with mixed activity
    cyc(4'd0, 1, 0, 8'hFF, '1, '0, '0, '1);
    cyc(4'd0, 1, 0, 8'h00, 16'h0001, '0, '0, 16'h0002);
    check("R3 set under activity", valid_mask, 16'h00FF);
    cyc(4'd0, 0, 1, 8'h00, 16'h0001, '0, '0, 16'h0002);
    check("R4 R5 R6 deferred clear", valid_mask, 16'h0003);
    cyc('0, 0, 0, 8'h00, 16'h0001, '0, '0, '0);
    check("R8 read shows pending as 1", {8'h00, bus_rdata}, 16'h0003);
    cyc('0, 0, 0, 8'h00, 16'h0001, 16'h0001, '0, '0);
    check("R6 store end clears", valid_mask, 16'h0001);
    idle();
    check("R5 tx done clears", valid_mask, 16'h0000);

    // R7 cancel a waiting clear
    cyc(4'd0, 1, 0, 8'h01, 16'h0001, '0, '0, '0);
    cyc(4'd0, 1, 0, 8'h00, 16'h0001, '0, '0, '0);
    cyc(4'd0, 1, 0, 8'h01, 16'h0001, '0, '0, '0);
    cyc('0, 0, 0, 8'h00, 16'h0001, '0, 16'h0001, '0);
    idle();
    check("R7 cancelled clear", valid_mask, 16'h0001);

    // R10 format write to an enabled buffer
    cyc(4'd2, 1, 0, 8'h00, '0, '0, '0, '0);
    idle();
    check("R10 format still written", ext_id_mask, 16'h3C00);
    check("R10 warn set", fmt_warn, 16'h0001);

    // R2 off-map write ignored, off-map read returns 0
    cyc(4'd6, 1, 1, 8'hFF, '0, '0, '0, '0);
    idle();
    check("R2 offmap write", valid_mask, 16'h0001);
    check("R2 offmap read", {8'h00, bus_rdata}, '0);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] b, s;
      b = N'($urandom & $urandom);
      s = N'($urandom & $urandom & $urandom);
      cyc(AW'($urandom_range(0, 5)), ($urandom_range(0, 9) < 3), ($urandom_range(0, 9) < 3),
          8'($urandom), b, b & N'($urandom & $urandom), b & N'($urandom & $urandom & $urandom), s);
    end
    idle();
    idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule